// File: doc/BRIEF.md
# 64-bit Integer ALU with Set-Compare

This block performs the single-cycle integer operations of a load/store RISC core on 64-bit data: wrapping add and subtract in signed and unsigned forms, bitwise AND, OR and XOR, left and right logical shifts, an arithmetic right shift, and signed and unsigned set-less-than. The set-less-than operations return exactly 0 or 1. Multiply and divide are multi-cycle operations and are handled elsewhere.

The decoder outside the block decides whether the second operand is a register or the 16-bit immediate. It signals this with `use_imm`. The block then extends the immediate in the way the operation needs: sign extension for arithmetic and compares, zero extension for the bitwise operations. A shift takes its amount either from a 6-bit instruction field or from the low six bits of `src_b`.

The result, the overflow flag and a valid bit are registered once. Each operation presented with `in_valid` therefore appears on the outputs one clock later.

Top module: `alu64_core`

## Requirements
- R1: Opcodes ADD=0, ADDU=1, SUB=2 and SUBU=3 produce the 64-bit sum or difference (src_a minus operand B) modulo 2^64.
- R2: `overflow` is 1 only for ADD or SUB when the two's-complement result does not fit in 64 bits. It is 0 for ADDU, SUBU and every other opcode.
- R3: Opcodes AND=4, OR=5 and XOR=6 produce the bitwise AND, OR and XOR of src_a and operand B.
- R4: When `use_imm` is 1, operand B is `imm16`. It is zero-extended for opcodes 4 to 6 and sign-extended for opcodes 0 to 3, 10 and 11. When `use_imm` is 0, operand B is `src_b`.
- R5: SLL=7 shifts src_a left and SRL=8 shifts it right, both filling vacated bits with zeros.
- R6: SRA=9 shifts src_a right and fills vacated high bits with copies of src_a bit 63.
- R7: The shift amount is `shamt_field` when `shamt_from_reg` is 0. When it is 1, the amount is src_b[5:0], and src_b[63:6] has no effect.
- R8: SLT=10 returns 1 when src_a is less than operand B as two's-complement numbers, and 0 otherwise (including when they are equal).
- R9: SLTU=11 returns 1 when src_a is less than operand B as unsigned numbers, and 0 otherwise.
- R10: An operation accepted with `in_valid`=1 appears on `result`, `overflow` and `out_valid`=1 at the next rising clock edge. After a cycle with `in_valid`=0, `out_valid` is 0 and `result` and `overflow` keep their values.
- R11: While `rst_n` is 0, `out_valid`, `result` and `overflow` are 0.
- R12: Opcodes 12 to 15 give result 0 and overflow 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An operation is presented this cycle |
| op | input | 4 | Operation code (see requirements) |
| src_a | input | 64 | First operand; the value shifted by shift operations |
| src_b | input | 64 | Register second operand; its low bits are a variable shift amount |
| imm16 | input | 16 | Immediate second operand |
| use_imm | input | 1 | Selects the extended immediate as operand B |
| shamt_field | input | 6 | Constant shift amount from the instruction |
| shamt_from_reg | input | 1 | Takes the shift amount from src_b[5:0] |
| out_valid | output | 1 | Result registers hold a new operation |
| result | output | 64 | Registered result |
| overflow | output | 1 | Registered signed overflow flag |

## Verification
The bench targets several corner cases, each with a specific wrong behaviour it would expose:
- Overflow at the signed extremes: the largest positive value plus one, and the most negative value minus one. It also checks that the unsigned variants of the same sums leave the flag at 0. A design that flags carries instead would fail there.
- Compares between values that differ only in bit 63, and compares of equal values. These separate the signed and unsigned orderings and expose a compare that reports less-than on equality.
- Shifts by 0 and by 63, and an arithmetic shift of a negative value. It also uses a register shift amount whose upper bits are set, which exposes a shifter that uses more than six bits.
- The immediate 0xFFFF through both a bitwise and an arithmetic opcode, which catches the wrong extension kind.
- A hold cycle after scrambled inputs, which shows whether the registers capture data without `in_valid`.

// File: rtl/alu64_pkg.sv
package alu64_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'd0,
        OP_ADDU = 4'd1,
        OP_SUB  = 4'd2,
        OP_SUBU = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_SLL  = 4'd7,
        OP_SRL  = 4'd8,
        OP_SRA  = 4'd9,
        OP_SLT  = 4'd10,
        OP_SLTU = 4'd11
    } alu_op_e;

    typedef enum logic [1:0] {
        BW_AND = 2'd0,
        BW_OR  = 2'd1,
        BW_XOR = 2'd2
    } bw_sel_e;

endpackage

// File: rtl/alu64_addsub.sv
module alu64_addsub #(
    parameter int W = 64
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         ovf_s,
    output logic         lt_s,
    output logic         lt_u
);

    logic [W-1:0] b_eff;
    logic [W:0]   wide;

    always_comb begin
        b_eff = sub ? ~b : b;
        wide  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
        sum   = wide[W-1:0];
        ovf_s = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
        lt_s  = sum[W-1] ^ ovf_s;
        lt_u  = ~wide[W];
    end

    // R8
    always_comb begin
        if (sub && (a == b)) begin
            eq_not_less_chk: assert (!lt_s && !lt_u);
        end
    end

endmodule

// File: rtl/alu64_bitwise.sv
module alu64_bitwise
    import alu64_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  bw_sel_e      sel,
    output logic [W-1:0] y
);

    always_comb begin
        case (sel)
            BW_AND:  y = a & b;
            BW_OR:   y = a | b;
            BW_XOR:  y = a ^ b;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/alu64_shift.sv
module alu64_shift #(
    parameter int W  = 64,
    parameter int AW = $clog2(W)
) (
    input  logic [W-1:0]  a,
    input  logic [AW-1:0] amt,
    input  logic          left,
    input  logic          arith,
    output logic [W-1:0]  y
);

    logic         fill;
    logic [W-1:0] rin;
    logic [W-1:0] stg [0:AW];

    assign fill = arith & ~left & a[W-1];

    // a left shift is a right shift of the bit-reversed word
    for (genvar i = 0; i < W; i++) begin : g_rev_in
        assign rin[i] = left ? a[W-1-i] : a[i];
    end

    assign stg[0] = rin;

    for (genvar s = 0; s < AW; s++) begin : g_stage
        localparam int STEP = 2 ** s;
        assign stg[s+1] = amt[s] ? {{STEP{fill}}, stg[s][W-1:STEP]} : stg[s];
    end

    for (genvar i = 0; i < W; i++) begin : g_rev_out
        assign y[i] = left ? stg[AW][W-1-i] : stg[AW][i];
    end

    always_comb begin
        // R6
        if (arith && !left && a[W-1] && (amt != '0)) begin
            sra_sign_fill_chk: assert (y[W-1]);
        end
        // R5
        if (left && (amt != '0)) begin
            sll_zero_fill_chk: assert (!y[0]);
        end
    end

endmodule

// File: rtl/alu64_core.sv
module alu64_core
    import alu64_pkg::*;
#(
    parameter  int DATA_W = 64,
    parameter  int IMM_W  = 16,
    localparam int SH_W   = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   op,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [IMM_W-1:0]  imm16,
    input  logic              use_imm,
    input  logic [SH_W-1:0]   shamt_field,
    input  logic              shamt_from_reg,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              overflow
);

    localparam int EXT_W = DATA_W - IMM_W;

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] res;
        logic              ovf;
        logic [OP_W-1:0]   op;
    } stage_t;

    stage_t stage_d, stage_q;

    alu_op_e           op_e;
    logic              is_bitwise;
    logic              is_sub;
    logic [DATA_W-1:0] imm_ext;
    logic [DATA_W-1:0] opb;
    logic [SH_W-1:0]   sh_amt;
    bw_sel_e           bw_sel;
    logic              sh_left;
    logic              sh_arith;

    logic [DATA_W-1:0] as_sum;
    logic              as_ovf;
    logic              as_lt_s;
    logic              as_lt_u;
    logic [DATA_W-1:0] bw_y;
    logic [DATA_W-1:0] sh_y;

    always_comb begin
        op_e       = alu_op_e'(op);
        is_bitwise = (op_e == OP_AND) || (op_e == OP_OR) || (op_e == OP_XOR);
        is_sub     = (op_e == OP_SUB) || (op_e == OP_SUBU) ||
                     (op_e == OP_SLT) || (op_e == OP_SLTU);
        imm_ext    = is_bitwise ? {{EXT_W{1'b0}}, imm16}
                                : {{EXT_W{imm16[IMM_W-1]}}, imm16};
        opb        = use_imm ? imm_ext : src_b;
        sh_amt     = shamt_from_reg ? src_b[SH_W-1:0] : shamt_field;
        sh_left    = (op_e == OP_SLL);
        sh_arith   = (op_e == OP_SRA);
        case (op_e)
            OP_OR:   bw_sel = BW_OR;
            OP_XOR:  bw_sel = BW_XOR;
            default: bw_sel = BW_AND;
        endcase
    end

    alu64_addsub #(.W(DATA_W)) u_addsub (
        .a     (src_a),
        .b     (opb),
        .sub   (is_sub),
        .sum   (as_sum),
        .ovf_s (as_ovf),
        .lt_s  (as_lt_s),
        .lt_u  (as_lt_u)
    );

    alu64_bitwise #(.W(DATA_W)) u_bitwise (
        .a   (src_a),
        .b   (opb),
        .sel (bw_sel),
        .y   (bw_y)
    );

    alu64_shift #(.W(DATA_W), .AW(SH_W)) u_shift (
        .a     (src_a),
        .amt   (sh_amt),
        .left  (sh_left),
        .arith (sh_arith),
        .y     (sh_y)
    );

    always_comb begin
        stage_d     = stage_q;
        stage_d.vld = 1'b0;
        if (in_valid) begin
            stage_d.vld = 1'b1;
            stage_d.op  = op;
            stage_d.ovf = 1'b0;
            case (op_e)
                OP_ADD, OP_SUB: begin
                    stage_d.res = as_sum;
                    stage_d.ovf = as_ovf;
                end
                OP_ADDU, OP_SUBU:       stage_d.res = as_sum;
                OP_AND, OP_OR, OP_XOR:  stage_d.res = bw_y;
                OP_SLL, OP_SRL, OP_SRA: stage_d.res = sh_y;
                OP_SLT:  stage_d.res = {{(DATA_W-1){1'b0}}, as_lt_s};
                OP_SLTU: stage_d.res = {{(DATA_W-1){1'b0}}, as_lt_u};
                default: stage_d.res = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign out_valid = stage_q.vld;
    assign result    = stage_q.res;
    assign overflow  = stage_q.ovf;

    // R10
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result) && $stable(overflow)));

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> ((stage_q.op == OP_ADD) || (stage_q.op == OP_SUB)));

    // R8
    set_bool_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ((stage_q.op == OP_SLT) || (stage_q.op == OP_SLTU)))
        |-> (result[DATA_W-1:1] == '0));

    // R12
    unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (stage_q.op > OP_SLTU)) |-> ((result == '0) && !overflow));

endmodule

// File: tb/alu64_core_test.sv
module alu64_core_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op = '0;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic [15:0] imm16 = '0;
    logic        use_imm = 1'b0;
    logic [5:0]  shamt_field = '0;
    logic        shamt_from_reg = 1'b0;
    logic        out_valid;
    logic [63:0] result;
    logic        overflow;

    int total = 0;
    int bad   = 0;
    bit ended = 0;

    logic [63:0] q_res [$];
    logic        q_ovf [$];
    string       q_tag [$];

    logic [63:0] last_res;
    logic        last_ovf;

    alu64_core uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .in_valid       (in_valid),
        .op             (op),
        .src_a          (src_a),
        .src_b          (src_b),
        .imm16          (imm16),
        .use_imm        (use_imm),
        .shamt_field    (shamt_field),
        .shamt_from_reg (shamt_from_reg),
        .out_valid      (out_valid),
        .result         (result),
        .overflow       (overflow)
    );

    always #5 clk = ~clk;

    function automatic logic [64:0] model(input logic [3:0] o, input logic [63:0] a,
                                          input logic [63:0] b, input logic [15:0] im,
                                          input logic ui, input logic [5:0] sf,
                                          input logic sr);
        logic [63:0] bb, r;
        logic        v;
        logic [5:0]  amt;
        logic [64:0] w;
        if (ui) bb = (o >= 4 && o <= 6) ? {48'h0, im} : {{48{im[15]}}, im};
        else    bb = b;
        amt = sr ? b[5:0] : sf;
        v = 1'b0;
        r = '0;
        case (o)
            4'd0:  begin r = a + bb; w = {a[63], a} + {bb[63], bb}; v = w[64] != w[63]; end
            4'd1:  r = a + bb;
            4'd2:  begin r = a - bb; w = {a[63], a} - {bb[63], bb}; v = w[64] != w[63]; end
            4'd3:  r = a - bb;
            4'd4:  r = a & bb;
            4'd5:  r = a | bb;
            4'd6:  r = a ^ bb;
            4'd7:  r = a << amt;
            4'd8:  r = a >> amt;
            4'd9:  r = $unsigned($signed(a) >>> amt);
            4'd10: r = ($signed(a) < $signed(bb)) ? 64'd1 : 64'd0;
            4'd11: r = (a < bb) ? 64'd1 : 64'd0;
            default: r = '0;
        endcase
        return {v, r};
    endfunction

    function automatic string tag_of(input logic [3:0] o);
        if (o <= 3)       return "R1";
        else if (o <= 6)  return "R3";
        else if (o <= 8)  return "R5";
        else if (o == 9)  return "R6";
        else if (o == 10) return "R8";
        else if (o == 11) return "R9";
        return "R12";
    endfunction

    task automatic check(input string tag, input logic [64:0] act, input logic [64:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual ovf=%0b res=%h expected ovf=%0b res=%h",
                     tag, act[64], act[63:0], exp[64], exp[63:0]);
        end
    endtask

    task automatic drive(input string tag, input logic [3:0] o, input logic [63:0] a,
                         input logic [63:0] b, input logic [15:0] im, input logic ui,
                         input logic [5:0] sf, input logic sr);
        logic [64:0] e;
        @(negedge clk);
        in_valid = 1'b1; op = o; src_a = a; src_b = b; imm16 = im;
        use_imm = ui; shamt_field = sf; shamt_from_reg = sr;
        e = model(o, a, b, im, ui, sf, sr);
        q_res.push_back(e[63:0]);
        q_ovf.push_back(e[64]);
        q_tag.push_back(tag);
        last_res = e[63:0];
        last_ovf = e[64];
    endtask

    // monitor: compares registered outputs against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && out_valid) begin
                if (q_res.size() == 0) begin
                    total++; bad++;
                    $display("FAIL R10: actual out_valid=1 expected out_valid=0 (no pending item)");
                end else begin
                    logic [63:0] er;
                    logic        eo;
                    string       et;
                    er = q_res.pop_front();
                    eo = q_ovf.pop_front();
                    et = q_tag.pop_front();
                    check(et, {overflow, result}, {eo, er});
                end
            end
        end
    end

    initial begin
        #1_000_000;
        if (!ended) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=complete");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    localparam logic [63:0] MAXP = 64'h7FFF_FFFF_FFFF_FFFF;
    localparam logic [63:0] MINN = 64'h8000_0000_0000_0000;
    localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

    initial begin
        // R11: reset state with a valid request presented during reset
        in_valid = 1'b1; op = 4'd0; src_a = 64'd9; src_b = 64'd9;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R11", {overflow, result}, 65'd0);
        total++;
        if (out_valid !== 1'b0) begin
            bad++;
            $display("FAIL R11: actual out_valid=%0b expected 0", out_valid);
        end
        in_valid = 1'b0;
        rst_n = 1'b1;

        // R1
        drive("R1", 4'd0, 64'd5, 64'd7, 16'h0, 0, 6'd0, 0);
        drive("R1", 4'd1, ONES, 64'd1, 16'h0, 0, 6'd0, 0);
        drive("R1", 4'd2, 64'd3, 64'd5, 16'h0, 0, 6'd0, 0);
        drive("R1", 4'd3, 64'd0, 64'd1, 16'h0, 0, 6'd0, 0);
        // R2: signed extremes and unsigned variants
        drive("R2", 4'd0, MAXP, 64'd1, 16'h0, 0, 6'd0, 0);
        drive("R2", 4'd2, MINN, 64'd1, 16'h0, 0, 6'd0, 0);
        drive("R2", 4'd1, MAXP, 64'd1, 16'h0, 0, 6'd0, 0);
        drive("R2", 4'd3, MINN, 64'd1, 16'h0, 0, 6'd0, 0);
        drive("R2", 4'd0, ONES, ONES, 16'h0, 0, 6'd0, 0);
        // R3
        drive("R3", 4'd4, 64'hF0F0_1234_5678_9ABC, 64'h0FF0_FFFF_0000_FFFF, 16'h0, 0, 6'd0, 0);
        drive("R3", 4'd5, 64'hF0F0_0000_0000_0001, 64'h0F0F_0000_0000_0010, 16'h0, 0, 6'd0, 0);
        drive("R3", 4'd6, ONES, 64'h0123_4567_89AB_CDEF, 16'h0, 0, 6'd0, 0);
        // R4: immediate extension kinds
        drive("R4", 4'd0, 64'd100, 64'd0, 16'hFFFF, 1, 6'd0, 0);
        drive("R4", 4'd4, ONES, 64'd0, 16'hFFFF, 1, 6'd0, 0);
        drive("R4", 4'd10, 64'd0, 64'd0, 16'h8000, 1, 6'd0, 0);
        drive("R4", 4'd11, 64'd5, 64'd0, 16'hFFFF, 1, 6'd0, 0);
        drive("R4", 4'd6, 64'd0, 64'd0, 16'h8001, 1, 6'd0, 0);
        // R5
        drive("R5", 4'd7, 64'h8000_0000_0000_0003, 64'd0, 16'h0, 0, 6'd1, 0);
        drive("R5", 4'd7, 64'd1, 64'd0, 16'h0, 0, 6'd63, 0);
        drive("R5", 4'd8, ONES, 64'd0, 16'h0, 0, 6'd3, 0);
        drive("R5", 4'd8, MINN, 64'd0, 16'h0, 0, 6'd0, 0);
        // R6
        drive("R6", 4'd9, 64'hF000_0000_0000_0100, 64'd0, 16'h0, 0, 6'd4, 0);
        drive("R6", 4'd9, MINN, 64'd0, 16'h0, 0, 6'd63, 0);
        drive("R6", 4'd9, MAXP, 64'd0, 16'h0, 0, 6'd62, 0);
        // R7: amount from register, upper bits ignored
        drive("R7", 4'd7, 64'd1, 64'hFFFF_FFFF_FFFF_FFC1, 16'h0, 0, 6'd9, 1);
        drive("R7", 4'd8, ONES, 64'h0000_0000_0000_0740, 16'h0, 0, 6'd5, 1);
        drive("R7", 4'd9, MINN, 64'h8000_0000_0000_0008, 16'h0, 0, 6'd0, 1);
        // R8
        drive("R8", 4'd10, ONES, 64'd1, 16'h0, 0, 6'd0, 0);
        drive("R8", 4'd10, 64'd1, ONES, 16'h0, 0, 6'd0, 0);
        drive("R8", 4'd10, MINN, MINN, 16'h0, 0, 6'd0, 0);
        drive("R8", 4'd10, MINN, MAXP, 16'h0, 0, 6'd0, 0);
        // R9
        drive("R9", 4'd11, ONES, 64'd1, 16'h0, 0, 6'd0, 0);
        drive("R9", 4'd11, 64'd1, ONES, 16'h0, 0, 6'd0, 0);
        drive("R9", 4'd11, 64'd7, 64'd7, 16'h0, 0, 6'd0, 0);
        // R12
        drive("R12", 4'd13, ONES, ONES, 16'hFFFF, 0, 6'd3, 0);
        drive("R12", 4'd15, MAXP, 64'd1, 16'h0, 0, 6'd0, 0);

        // mixed vectors across all opcodes
        for (int i = 0; i < 300; i++) begin
            logic [3:0] ro;
            ro = 4'($urandom_range(0, 15));
            drive(tag_of(ro), ro, {$urandom, $urandom}, {$urandom, $urandom},
                  16'($urandom), 1'($urandom), 6'($urandom), 1'($urandom));
        end

        // finish with a signed overflow so the hold check covers overflow=1
        drive("R2", 4'd0, MAXP, MAXP, 16'h0, 0, 6'd0, 0);

        // R10: idle cycle with scrambled inputs must not disturb outputs
        @(negedge clk);
        in_valid = 1'b0; op = 4'd5; src_a = 64'h1234; src_b = ONES; use_imm = 1'b0;
        @(negedge clk);
        check("R10", {overflow, result}, {last_ovf, last_res});
        total++;
        if (out_valid !== 1'b0) begin
            bad++;
            $display("FAIL R10: actual out_valid=%0b expected 0", out_valid);
        end
        total++;
        if (q_res.size() != 0) begin
            bad++;
            $display("FAIL R10: actual pending=%0d expected 0", q_res.size());
        end

        ended = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule